// File: doc/BRIEF.md
# Exception Control Register Bank

This block is the software-visible register bank that sits next to an interrupt prioritiser. It turns word writes at fixed offsets into one-cycle strobes that set or clear the pending state of three system exceptions: non-maskable, pendable service and timer. It assembles a composite status word from the prioritiser's view of active and pending vectors. It also holds the configuration the prioritiser and the core consume: a vector table base, packed 8-bit priorities for system exceptions 4 to 15, and enables for the memory-management, bus and usage fault handlers. A reset/control register raises a one-cycle system reset request, but only when the write carries the correct 16-bit key.

Accesses are single-cycle word requests. `req` is held for one cycle, and `we` selects a write. For a read, the data and the error flag appear in the cycle after the request. Vector numbers on the prioritiser inputs use the numbering in which external interrupts start at 16. A vector value of 0 means "none". The prioritiser owns every pending and active flag. This bank only reports those flags and requests changes to them.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After synchronous reset, `vec_base`, `sys_prio` and `fault_en` are zero, as are all strobes, `sys_reset_req`, `rd_data` and `rd_err`. Priority zero is the highest priority.
- R2: A write to offset 0xD04 with bit 31 set pulses `pend_set[0]` (non-maskable) for exactly one cycle, the cycle after the write.
- R3: At 0xD04, bit 28 pulses `pend_set[1]` (pendable service). Bit 27 pulses `pend_clr[0]` only when bit 28 is clear in the same write, so set wins over clear.
- R4: At 0xD04, bit 26 pulses `pend_set[2]` (timer). Bit 25 pulses `pend_clr[1]` only when bit 26 is clear in the same write.
- R5: A read of 0xD04 returns these fields:
  - `act_vec` in bits 8:0;
  - `pend_vec` in bits 20:12;
  - `ext_pend` in bit 22;
  - the pending flags of exception 15 (timer) in bit 26, exception 14 (pendable service) in bit 28 and exception 2 (non-maskable) in bit 31.
  All other bits are zero except bit 11.
- R6: Bit 11 of the 0xD04 read is 1 when `act_vec` is 0 or `act_nested` is 0, and 0 otherwise.
- R7: Offset 0xD08 stores the written word with bits 6:0 forced to zero. It drives `vec_base` and reads back the stored value.
- R8: A write to 0xD0C pulses `sys_reset_req` for one cycle only if bits 31:16 equal 0x05FA and bit 0 or bit 2 is set. Any other write has no effect. A read of 0xD0C returns 0xFA050000.
- R9: Offsets 0xD18, 0xD1C and 0xD20 each hold four 8-bit priorities, least significant byte first, for handlers 4–7, 8–11 and 12–15. Handler h appears on `sys_prio[8*(h-4) +: 8]`, and each word reads back as written.
- R10: At 0xD24, written bits 16, 17 and 18 set `fault_en[0]` (memory management), `fault_en[1]` (bus) and `fault_en[2]` (usage). Other written bits have no effect.
- R11: A read of 0xD24 returns:
  - the active flags of exceptions 4, 5, 6, 11, 12, 14 and 15 in bits 0, 1, 3, 7, 8, 10 and 11;
  - the pending flags of exceptions 6, 4, 5 and 11 in bits 12, 13, 14 and 15;
  - `fault_en` in bits 18:16.
- R12: Any access to an offset other than the six listed, including a misaligned one, returns `rd_data` 0. It raises `rd_err` for one cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (12) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read request |
| rd_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| act_vec | input | VEC_W (9) | Active vector from the prioritiser, 0 = none |
| act_nested | input | 1 | The active exception has a preempted one beneath it |
| pend_vec | input | VEC_W (9) | Highest pending vector, 0 = none |
| ext_pend | input | 1 | Some external interrupt is pending |
| exc_pend | input | 16 | Pending flags of system exceptions, indexed by exception number |
| exc_active | input | 16 | Active flags of system exceptions, indexed by exception number |
| pend_set | output | 3 | Set strobes: [0] non-maskable, [1] pendable service, [2] timer |
| pend_clr | output | 2 | Clear strobes: [0] pendable service, [1] timer |
| sys_reset_req | output | 1 | One-cycle system reset request |
| vec_base | output | 32 | Vector table base |
| sys_prio | output | 96 | Priorities of handlers 4..15, 8 bits each |
| fault_en | output | 3 | Enables of the memory-management, bus and usage fault handlers |

## Verification
The pending-control word is driven with each set bit alone, with each clear bit alone, and with each set and clear bit together. This separates a correct set-wins rule from one where clear wins or both strobes fire. The status read is tried with three prioritiser states:
- a nested active vector with all pending sources raised;
- no active vector while `act_nested` is high;
- an active vector without nesting.
Together these expose wrong field positions and a wrong bit-11 rule. Key writes with and without the key, and with each request bit, separate gated from ungated reset requests. Unmapped and misaligned accesses, followed by a read-back of the enables, show that errors leave state untouched.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

    localparam int DATA_W        = 32;
    localparam int PRIO_W        = 8;
    localparam int PRIO_PER_REG  = DATA_W / PRIO_W;
    localparam int NUM_PRIO_REGS = 3;
    localparam int PRIO_FLAT_W   = NUM_PRIO_REGS * PRIO_PER_REG * PRIO_W;
    localparam int NUM_EXC       = 16;

    localparam logic [11:0] OFS_ICS   = 12'hD04;
    localparam logic [11:0] OFS_VTOR  = 12'hD08;
    localparam logic [11:0] OFS_RSTC  = 12'hD0C;
    localparam logic [11:0] OFS_PRIO0 = 12'hD18;
    localparam logic [11:0] OFS_HCS   = 12'hD24;

    localparam logic [15:0] RST_KEY   = 16'h05FA;
    localparam logic [31:0] RSTC_RDVAL = 32'hFA05_0000;
    localparam int          VTOR_LSB  = 7;

    // exception numbers
    localparam int EXC_NMI  = 2;
    localparam int EXC_MEM  = 4;
    localparam int EXC_BUS  = 5;
    localparam int EXC_USE  = 6;
    localparam int EXC_SVC  = 11;
    localparam int EXC_DBG  = 12;
    localparam int EXC_PSV  = 14;
    localparam int EXC_TICK = 15;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_ICS, SEL_VTOR, SEL_RSTC, SEL_PRIO, SEL_HCS
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] prio_idx;
    } dec_t;

    typedef struct packed {
        logic tick_clr;
        logic tick_set;
        logic psv_clr;
        logic psv_set;
        logic nmi_set;
    } pend_cmd_t;

    // set beats clear within one write
    function automatic pend_cmd_t decode_pend_word(input logic [DATA_W-1:0] w);
        pend_cmd_t c;
        c.nmi_set  = w[31];
        c.psv_set  = w[28];
        c.psv_clr  = w[27] & ~w[28];
        c.tick_set = w[26];
        c.tick_clr = w[25] & ~w[26];
        return c;
    endfunction

    function automatic logic key_ok(input logic [DATA_W-1:0] w);
        return (w[31:16] == RST_KEY) && (w[2] || w[0]);
    endfunction

endpackage

// File: rtl/exc_addr_dec.sv
module exc_addr_dec
    import exc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec = '{sel: SEL_NONE, prio_idx: 2'd0};
        if (addr == ADDR_W'(OFS_ICS))  dec.sel = SEL_ICS;
        if (addr == ADDR_W'(OFS_VTOR)) dec.sel = SEL_VTOR;
        if (addr == ADDR_W'(OFS_RSTC)) dec.sel = SEL_RSTC;
        if (addr == ADDR_W'(OFS_HCS))  dec.sel = SEL_HCS;
        for (int i = 0; i < NUM_PRIO_REGS; i++) begin
            if (addr == ADDR_W'(OFS_PRIO0 + 12'(4 * i))) begin
                dec.sel      = SEL_PRIO;
                dec.prio_idx = 2'(i);
            end
        end
    end
endmodule

// File: rtl/exc_prio_bank.sv
module exc_prio_bank
    import exc_ctrl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             idx,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rd_word,
    output logic [PRIO_FLAT_W-1:0] prio_flat
);
    logic [DATA_W-1:0] word_q [NUM_PRIO_REGS];

    for (genvar g = 0; g < NUM_PRIO_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                word_q[g] <= '0;
            else if (wr_en && idx == 2'(g))
                word_q[g] <= wdata;
        end
        assign prio_flat[g*DATA_W +: DATA_W] = word_q[g];
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PRIO_REGS; i++)
            if (idx == 2'(i)) rd_word = word_q[i];
    end
endmodule

// File: rtl/exc_status_pack.sv
module exc_status_pack
    import exc_ctrl_pkg::*;
#(
    parameter int VEC_W = 9
) (
    input  logic [VEC_W-1:0]   act_vec,
    input  logic               act_nested,
    input  logic [VEC_W-1:0]   pend_vec,
    input  logic               ext_pend,
    input  logic [NUM_EXC-1:0] exc_pend,
    input  logic [NUM_EXC-1:0] exc_active,
    input  logic [2:0]         fault_en,
    output logic [DATA_W-1:0]  ics_word,
    output logic [DATA_W-1:0]  hcs_word
);
    localparam int PEND_LSB = 12;

    always_comb begin
        ics_word                   = '0;
        ics_word[VEC_W-1:0]        = act_vec;
        ics_word[11]               = (act_vec == '0) || !act_nested;
        ics_word[PEND_LSB +: VEC_W] = pend_vec;
        ics_word[22]               = ext_pend;
        ics_word[26]               = exc_pend[EXC_TICK];
        ics_word[28]               = exc_pend[EXC_PSV];
        ics_word[31]               = exc_pend[EXC_NMI];
    end

    always_comb begin
        hcs_word        = '0;
        hcs_word[0]     = exc_active[EXC_MEM];
        hcs_word[1]     = exc_active[EXC_BUS];
        hcs_word[3]     = exc_active[EXC_USE];
        hcs_word[7]     = exc_active[EXC_SVC];
        hcs_word[8]     = exc_active[EXC_DBG];
        hcs_word[10]    = exc_active[EXC_PSV];
        hcs_word[11]    = exc_active[EXC_TICK];
        hcs_word[12]    = exc_pend[EXC_USE];
        hcs_word[13]    = exc_pend[EXC_MEM];
        hcs_word[14]    = exc_pend[EXC_BUS];
        hcs_word[15]    = exc_pend[EXC_SVC];
        hcs_word[18:16] = fault_en;
    end
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
    import exc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int VEC_W  = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rd_data,
    output logic                   rd_err,
    input  logic [VEC_W-1:0]       act_vec,
    input  logic                   act_nested,
    input  logic [VEC_W-1:0]       pend_vec,
    input  logic                   ext_pend,
    input  logic [15:0]            exc_pend,
    input  logic [15:0]            exc_active,
    output logic [2:0]             pend_set,
    output logic [1:0]             pend_clr,
    output logic                   sys_reset_req,
    output logic [31:0]            vec_base,
    output logic [PRIO_FLAT_W-1:0] sys_prio,
    output logic [2:0]             fault_en
);
    dec_t              dec;
    pend_cmd_t         cmd_q;
    logic [31:0]       vbase_q, rd_q, prio_rd, ics_word, hcs_word, rd_mux;
    logic [2:0]        en_q;
    logic              rst_req_q, err_q;
    logic              wr;

    assign wr = req && we;

    exc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .dec(dec));

    exc_prio_bank u_prio (
        .clk(clk), .rst(rst),
        .wr_en(wr && dec.sel == SEL_PRIO),
        .idx(dec.prio_idx), .wdata(wdata),
        .rd_word(prio_rd), .prio_flat(sys_prio)
    );

    exc_status_pack #(.VEC_W(VEC_W)) u_stat (
        .act_vec(act_vec), .act_nested(act_nested), .pend_vec(pend_vec),
        .ext_pend(ext_pend), .exc_pend(exc_pend), .exc_active(exc_active),
        .fault_en(en_q), .ics_word(ics_word), .hcs_word(hcs_word)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_ICS:  rd_mux = ics_word;
            SEL_VTOR: rd_mux = vbase_q;
            SEL_RSTC: rd_mux = RSTC_RDVAL;
            SEL_PRIO: rd_mux = prio_rd;
            SEL_HCS:  rd_mux = hcs_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            vbase_q   <= '0;
            en_q      <= '0;
            rst_req_q <= 1'b0;
            err_q     <= 1'b0;
            rd_q      <= '0;
        end else begin
            cmd_q     <= '0;
            rst_req_q <= 1'b0;
            err_q     <= req && dec.sel == SEL_NONE;
            rd_q      <= (req && !we) ? rd_mux : '0;
            if (wr) begin
                case (dec.sel)
                    SEL_ICS:  cmd_q   <= decode_pend_word(wdata);
                    SEL_VTOR: vbase_q <= {wdata[31:VTOR_LSB], VTOR_LSB'(0)};
                    SEL_RSTC: rst_req_q <= key_ok(wdata);
                    SEL_HCS:  en_q    <= wdata[18:16];
                    default:  ;
                endcase
            end
        end
    end

    assign pend_set      = {cmd_q.tick_set, cmd_q.psv_set, cmd_q.nmi_set};
    assign pend_clr      = {cmd_q.tick_clr, cmd_q.psv_clr};
    assign sys_reset_req = rst_req_q;
    assign vec_base      = vbase_q;
    assign fault_en      = en_q;
    assign rd_data       = rd_q;
    assign rd_err        = err_q;
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk
    import exc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rd_data,
    input logic              rd_err,
    input logic [2:0]        pend_set,
    input logic [1:0]        pend_clr,
    input logic              sys_reset_req,
    input logic [31:0]       vec_base,
    input logic [2:0]        fault_en
);
    logic ics_wr, hcs_wr, rst_wr;
    assign ics_wr = req && we && addr == ADDR_W'(OFS_ICS);
    assign hcs_wr = req && we && addr == ADDR_W'(OFS_HCS);
    assign rst_wr = req && we && addr == ADDR_W'(OFS_RSTC);

    a_r2_nmi_cause: assert property (@(posedge clk) disable iff (rst)
        pend_set[0] |-> $past(ics_wr && wdata[31]));

    a_r3_psv_clr_loses: assert property (@(posedge clk) disable iff (rst)
        pend_clr[0] |-> $past(ics_wr && wdata[27] && !wdata[28]));

    a_r4_tick_clr_loses: assert property (@(posedge clk) disable iff (rst)
        pend_clr[1] |-> $past(ics_wr && wdata[25] && !wdata[26]));

    a_r7_base_aligned: assert property (@(posedge clk) disable iff (rst)
        vec_base[6:0] == 7'd0);

    a_r8_key_gate: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> $past(rst_wr && wdata[31:16] == RST_KEY));

    a_r10_en_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(hcs_wr) |-> $stable(fault_en));

    a_r12_err_zero: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_data == 32'd0 && $past(req)));
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .rd_err(rd_err), .pend_set(pend_set),
    .pend_clr(pend_clr), .sys_reset_req(sys_reset_req),
    .vec_base(vec_base), .fault_en(fault_en)
);

// File: tb/exc_ctrl_regs_bench.sv
module exc_ctrl_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, req, we;
    logic [11:0] addr;
    logic [31:0] wdata, rd_data;
    logic        rd_err;
    logic [8:0]  act_vec, pend_vec;
    logic        act_nested, ext_pend;
    logic [15:0] exc_pend, exc_active;
    logic [2:0]  pend_set, fault_en;
    logic [1:0]  pend_clr;
    logic        sys_reset_req;
    logic [31:0] vec_base;
    logic [95:0] sys_prio;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_ctrl_regs u_exc_ctrl_regs (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .rd_err(rd_err), .act_vec(act_vec),
        .act_nested(act_nested), .pend_vec(pend_vec), .ext_pend(ext_pend),
        .exc_pend(exc_pend), .exc_active(exc_active), .pend_set(pend_set),
        .pend_clr(pend_clr), .sys_reset_req(sys_reset_req),
        .vec_base(vec_base), .sys_prio(sys_prio), .fault_en(fault_en)
    );

    task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rd_data; e = rd_err;
    endtask

    task automatic t_reset;
        check("R1 vec_base", vec_base, 0);
        check("R1 sys_prio", sys_prio, 0);
        check("R1 fault_en", fault_en, 0);
        check("R1 strobes", {pend_set, pend_clr, sys_reset_req}, 0);
        check("R1 rd", {rd_data, rd_err}, 0);
    endtask

    task automatic pend_case(input string tag, input logic [31:0] w,
                             input logic [2:0] es, input logic [1:0] ec);
        do_write(12'hD04, w);
        check(tag, {pend_set, pend_clr}, {es, ec});
        @(negedge clk);
        check({tag, " pulse ends"}, {pend_set, pend_clr}, 0);
    endtask

    task automatic t_pend;
        pend_case("R2 nmi set",        32'h8000_0000, 3'b001, 2'b00);
        pend_case("R3 psv set",        32'h1000_0000, 3'b010, 2'b00);
        pend_case("R3 psv clr",        32'h0800_0000, 3'b000, 2'b01);
        pend_case("R3 psv set wins",   32'h1800_0000, 3'b010, 2'b00);
        pend_case("R4 tick set",       32'h0400_0000, 3'b100, 2'b00);
        pend_case("R4 tick clr",       32'h0200_0000, 3'b000, 2'b10);
        pend_case("R4 tick set wins",  32'h0600_0000, 3'b100, 2'b00);
    endtask

    function automatic logic [31:0] exp_ics(input logic [8:0] av, input logic nest,
            input logic [8:0] pv, input logic ep, input logic [15:0] pf);
        logic [31:0] v = 32'(av) | (32'(pv) << 12);
        v[11] = (av == 0) || !nest;
        v[22] = ep; v[26] = pf[15]; v[28] = pf[14]; v[31] = pf[2];
        return v;
    endfunction

    task automatic ics_case(input string tag, input logic [8:0] av, input logic nest,
            input logic [8:0] pv, input logic ep, input logic [15:0] pf);
        logic [31:0] d; logic e;
        act_vec = av; act_nested = nest; pend_vec = pv; ext_pend = ep; exc_pend = pf;
        do_read(12'hD04, d, e);
        check(tag, {d, e}, {exp_ics(av, nest, pv, ep, pf), 1'b0});
    endtask

    task automatic t_status;
        ics_case("R5 R6 nested active", 9'd20, 1'b1, 9'd33, 1'b1, 16'h8004);
        ics_case("R6 none active",      9'd0,  1'b1, 9'd0,  1'b0, 16'h4000);
        ics_case("R5 R6 flat active",   9'd3,  1'b0, 9'd300, 1'b0, 16'h0000);
        exc_pend = 16'h0;
    endtask

    task automatic t_vtor;
        logic [31:0] d; logic e;
        do_write(12'hD08, 32'hFFFF_FFFF);
        check("R7 base out", vec_base, 32'hFFFF_FF80);
        do_read(12'hD08, d, e);
        check("R7 base read", d, 32'hFFFF_FF80);
    endtask

    task automatic t_rstc;
        logic [31:0] d; logic e;
        do_write(12'hD0C, 32'h05FA_0001);
        check("R8 key bit0", sys_reset_req, 1);
        do_write(12'hD0C, 32'h05FA_0004);
        check("R8 key bit2", sys_reset_req, 1);
        do_write(12'hD0C, 32'h05FA_0002);
        check("R8 key no req bit", sys_reset_req, 0);
        do_write(12'hD0C, 32'h1234_0005);
        check("R8 bad key", sys_reset_req, 0);
        do_read(12'hD0C, d, e);
        check("R8 read", d, 32'hFA05_0000);
    endtask

    task automatic t_prio;
        logic [31:0] d; logic e;
        do_write(12'hD18, 32'h4433_2211);
        do_write(12'hD20, 32'hF0E0_D0C0);
        do_write(12'hD1C, 32'h8877_6655);
        check("R9 flat", sys_prio, 96'hF0E0_D0C0_8877_6655_4433_2211);
        check("R9 handler 13", sys_prio[8*(13-4) +: 8], 8'hD0);
        do_read(12'hD1C, d, e);
        check("R9 read mid", d, 32'h8877_6655);
    endtask

    task automatic t_hcs;
        logic [31:0] d; logic e;
        do_write(12'hD24, 32'hFFF8_FFFF);
        check("R10 only enables", fault_en, 3'b000);
        do_write(12'hD24, 32'h0005_0000);
        check("R10 mem+usage", fault_en, 3'b101);
        exc_active = 16'hFFFF; exc_pend = 16'h0;
        do_read(12'hD24, d, e);
        check("R11 all active", d, 32'h0005_0D8B);
        exc_active = 16'h0800; exc_pend = 16'h0010;
        do_read(12'hD24, d, e);
        check("R11 svc act mem pend", d, 32'h0005_2080);
        exc_active = 16'h0; exc_pend = 16'h0;
    endtask

    task automatic t_unmapped;
        logic [31:0] d; logic e;
        do_read(12'hD10, d, e);
        check("R12 unmapped read", {d, e}, {32'h0, 1'b1});
        @(negedge clk);
        check("R12 err one cycle", rd_err, 0);
        do_read(12'hD06, d, e);
        check("R12 misaligned", {d, e}, {32'h0, 1'b1});
        do_write(12'hD28, 32'h0007_0000);
        check("R12 write err", rd_err, 1);
        do_read(12'hD24, d, e);
        check("R12 state kept", {d[18:16], e}, {3'b101, 1'b0});
    endtask

    initial begin
        rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        act_vec = '0; act_nested = 1'b0; pend_vec = '0; ext_pend = 1'b0;
        exc_pend = '0; exc_active = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pend();
        t_status();
        t_vtor();
        t_rstc();
        t_prio();
        t_hcs();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule